// File: doc/BRIEF.md
# Pipelined Dot-Product Accumulator

This block forms the inner product of two signed integer vectors that arrive one element pair per clock. Each pair goes through a multiplier split into several register segments. The products then enter an adder that is also split into segments, and the adder's output loops back to its own input. Because an operand fed into that loop returns only after the full adder depth, the running total is not one number. It is spread over as many interleaved partial sums as the adder has segments. All segment registers start at zero, so the loop returns zero while the pipes fill.

The source marks the final pair of a vector with a last flag. Once that product has entered the adder, the block spends one pass through the adder input folding the partial sums together. It then presents the total on the result port with a one-cycle done pulse and clears the loop for the next vector. Pairs offered between the last flag and the done pulse are dropped. A new vector may begin in the very cycle the done pulse is high. The integer units have the segment depth that floating-point units would have.

Top module: `dot_pipe_acc`

## Requirements
- R1: While reset is asserted, and after its release until the first result, `res_valid` is 0 and `res_sum` is 0. The first vector after reset is summed from a zero start.
- R2: The result equals the sum of a[i]*b[i] over the accepted pairs of the vector, with operands read as signed two's complement of DW bits. It is given as a signed value of AW = 2*DW + clog2(MAX_LEN) bits.
- R3: A pair is accepted on any clock edge where `in_valid` is 1 and the block is not finishing a vector. Cycles with `in_valid` at 0 add nothing, whether they fall between pairs or among them.
- R4: Any vector length from 1 to MAX_LEN gives the correct sum, including lengths that are not a multiple of the adder depth and a full-length vector of extreme operands.
- R5: `res_valid` is high for exactly one cycle. It rises on the clock edge that is MUL_STAGES + ADD_STAGES edges after the edge that accepted the pair carrying `in_last`.
- R6: Pairs offered after the accepted last pair, up to and including the edge that raises `res_valid`, are ignored. They change neither that result nor the next one.
- R7: A pair offered in the cycle `res_valid` is high is accepted as the first element of the next vector. Back-to-back vectors leave no residue in each other's sums.
- R8: `res_sum` keeps its value in every cycle in which `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operand pair is offered this cycle |
| in_last | input | 1 | The offered pair closes the vector |
| in_a | input | DW | First operand, signed |
| in_b | input | DW | Second operand, signed |
| res_valid | output | 1 | Single-cycle done pulse |
| res_sum | output | AW | Signed dot product, held between pulses |

## Verification
A partial sum left stale or lost in the feedback loop shows up only at the next done pulse, as a total that is off by one slot's contribution. Such an error therefore surfaces one multiplier depth plus one adder depth after the last pair. Vector lengths that leave slots empty, and back-to-back vectors, expose a loop that is not cleared or a fold that reads the wrong segment. A wrong control state shows sooner: pairs taken during the fold, or a pulse on the wrong edge, are caught in the cycle they happen.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_DRAIN = 2'd1,
      ST_FOLD  = 2'd2
   } dpa_state_e;
endpackage

// File: rtl/dpa_mul_pipe.sv
module dpa_mul_pipe #(
   parameter int DW     = 8,
   parameter int STAGES = 4,
   localparam int PW    = 2 * DW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 take_last,
   input  logic signed [DW-1:0] op_a,
   input  logic signed [DW-1:0] op_b,
   output logic                 prod_v,
   output logic                 prod_last,
   output logic signed [PW-1:0] prod
);
   logic signed [PW-1:0] seg_p [STAGES];
   logic [STAGES-1:0]    seg_v;
   logic [STAGES-1:0]    seg_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) seg_p[i] <= '0;
         seg_v <= '0;
         seg_l <= '0;
      end else begin
         seg_p[0] <= op_a * op_b;
         seg_v[0] <= take;
         seg_l[0] <= take & take_last;
         for (int i = 1; i < STAGES; i++) begin
            seg_p[i] <= seg_p[i-1];
            seg_v[i] <= seg_v[i-1];
            seg_l[i] <= seg_l[i-1];
         end
      end
   end

   assign prod      = seg_p[STAGES-1];
   assign prod_v    = seg_v[STAGES-1];
   assign prod_last = seg_l[STAGES-1];
endmodule

// File: rtl/dpa_add_ring.sv
module dpa_add_ring #(
   parameter int AW     = 24,
   parameter int STAGES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 fold,
   input  logic                 fold_first,
   input  logic                 prod_v,
   input  logic signed [AW-1:0] prod,
   output logic signed [AW-1:0] sum_in
);
   logic signed [AW-1:0] seg [STAGES];
   logic signed [AW-1:0] addend;
   logic signed [AW-1:0] loop_back;

   assign loop_back = seg[STAGES-1];

   always_comb begin
      if (fold) addend = fold_first ? '0 : seg[0];
      else      addend = prod_v ? prod : '0;
      sum_in = loop_back + addend;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) seg[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < STAGES; i++) seg[i] <= '0;
      end else begin
         seg[0] <= sum_in;
         for (int i = 1; i < STAGES; i++) seg[i] <= seg[i-1];
      end
   end
endmodule

// File: rtl/dpa_ctrl.sv
module dpa_ctrl
   import dpa_pkg::*;
#(
   parameter int ADD_STAGES = 4,
   localparam int CW = (ADD_STAGES > 1) ? $clog2(ADD_STAGES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_last,
   input  logic tail,
   output logic accept,
   output logic fold,
   output logic fold_first,
   output logic fold_end
);
   dpa_state_e st;
   logic [CW-1:0] cnt;

   assign accept     = (st == ST_RUN) && in_valid;
   assign fold       = (st == ST_FOLD);
   assign fold_first = fold && (cnt == '0);
   assign fold_end   = fold && (cnt == CW'(ADD_STAGES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_RUN;
         cnt <= '0;
      end else begin
         unique case (st)
            ST_RUN:   if (accept && in_last) st <= ST_DRAIN;
            ST_DRAIN: if (tail) begin
                         st  <= ST_FOLD;
                         cnt <= '0;
                      end
            ST_FOLD:  begin
                         cnt <= cnt + 1'b1;
                         if (fold_end) st <= ST_RUN;
                      end
            default:  st <= ST_RUN;
         endcase
      end
   end
endmodule

// File: rtl/dot_pipe_acc.sv
module dot_pipe_acc #(
   parameter int DW         = 8,
   parameter int MUL_STAGES = 4,
   parameter int ADD_STAGES = 4,
   parameter int MAX_LEN    = 256,
   localparam int PW        = 2 * DW,
   localparam int AW        = PW + $clog2(MAX_LEN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_last,
   input  logic signed [DW-1:0] in_a,
   input  logic signed [DW-1:0] in_b,
   output logic                 res_valid,
   output logic signed [AW-1:0] res_sum
);
   if (DW < 2) begin : g_bad_dw
      $error("dot_pipe_acc: DW must be at least 2");
   end
   if (MUL_STAGES < 1 || ADD_STAGES < 1) begin : g_bad_depth
      $error("dot_pipe_acc: segment counts must be at least 1");
   end
   if (MAX_LEN < 1) begin : g_bad_len
      $error("dot_pipe_acc: MAX_LEN must be at least 1");
   end

   logic                 acc_take;
   logic                 fold, fold_first, fold_end;
   logic                 mul_v, mul_last;
   logic signed [PW-1:0] mul_p;
   logic signed [AW-1:0] prod_ext;
   logic signed [AW-1:0] sum_in;

   dpa_ctrl #(.ADD_STAGES(ADD_STAGES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .tail       (mul_v & mul_last),
      .accept     (acc_take),
      .fold       (fold),
      .fold_first (fold_first),
      .fold_end   (fold_end)
   );

   dpa_mul_pipe #(.DW(DW), .STAGES(MUL_STAGES)) u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (acc_take),
      .take_last (in_last),
      .op_a      (in_a),
      .op_b      (in_b),
      .prod_v    (mul_v),
      .prod_last (mul_last),
      .prod      (mul_p)
   );

   assign prod_ext = AW'(mul_p);

   dpa_add_ring #(.AW(AW), .STAGES(ADD_STAGES)) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (fold_end),
      .fold       (fold),
      .fold_first (fold_first),
      .prod_v     (mul_v),
      .prod       (prod_ext),
      .sum_in     (sum_in)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_sum   <= '0;
      end else begin
         res_valid <= fold_end;
         if (fold_end) res_sum <= sum_in;
      end
   end
endmodule

// File: rtl/dpa_chk.sv
module dpa_chk #(
   parameter int LAT = 8,
   parameter int AW  = 24,
   localparam int CW = $clog2(LAT + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          accept,
   input logic          in_last,
   input logic          res_valid,
   input logic [AW-1:0] res_sum
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (accept && in_last) cnt <= CW'(LAT);
      else if (cnt != '0)        cnt <= cnt - 1'b1;
   end

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   a_r5_on_time: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(1)) |=> res_valid);

   a_r5_not_early: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($past(cnt) == CW'(1)));

   a_r6_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> !accept);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable(res_sum));
endmodule

bind dot_pipe_acc dpa_chk #(.LAT(MUL_STAGES + ADD_STAGES), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .accept    (acc_take),
   .in_last   (in_last),
   .res_valid (res_valid),
   .res_sum   (res_sum)
);

// File: tb/sim_dot_pipe_acc.sv
`timescale 1ns/1ps
module sim_dot_pipe_acc;
   localparam int DW  = 8;
   localparam int MS  = 4;
   localparam int AS  = 4;
   localparam int ML  = 256;
   localparam int AW  = 2 * DW + $clog2(ML);
   localparam int LAT = MS + AS;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_last = 1'b0;
   logic signed [DW-1:0] in_a = '0, in_b = '0;
   logic res_valid;
   logic signed [AW-1:0] res_sum;

   int checks = 0, errors = 0, cyc = 0;
   string tag = "R1";

   longint acc = 0, pend = 0, exp_sum = 0, edge_n = 0, due = 0;
   bit busy = 1'b0, exp_valid = 1'b0;

   dot_pipe_acc #(.DW(DW), .MUL_STAGES(MS), .ADD_STAGES(AS), .MAX_LEN(ML)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
      .in_a(in_a), .in_b(in_b), .res_valid(res_valid), .res_sum(res_sum));

   always #2.5 clk = ~clk;

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // behavioural reference: acceptance, scheduled completion, held result
   always @(posedge clk) begin
      bit was_busy;
      if (!rst_n) begin
         acc = 0; busy = 0; exp_valid = 0; exp_sum = 0; edge_n = 0;
      end else begin
         was_busy  = busy;
         edge_n++;
         exp_valid = 0;
         if (!was_busy && in_valid) begin
            acc += longint'(in_a) * longint'(in_b);
            if (in_last) begin
               pend = acc; acc = 0; busy = 1; due = edge_n + LAT;
            end
         end
         if (was_busy && edge_n == due) begin
            busy = 0; exp_valid = 1; exp_sum = pend;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         summary();
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(res_valid === exp_valid, "R5 done pulse", longint'(res_valid), longint'(exp_valid));
         if (exp_valid)
            check(longint'(res_sum) == exp_sum, tag, longint'(res_sum), exp_sum);
         else
            check(longint'(res_sum) == exp_sum, "R8 hold", longint'(res_sum), exp_sum);
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      in_valid = 0; in_last = 0;
   endtask

   task automatic send_vec(int len, int gap_pct, int extra, bit maxval);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         while (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
            in_valid = 0; in_last = 0;
            @(negedge clk);
         end
         in_valid = 1;
         in_last  = (i == len - 1);
         in_a = maxval ? DW'(-128) : DW'($urandom);
         in_b = maxval ? DW'(-128) : DW'($urandom);
      end
      for (int j = 0; j < extra; j++) begin
         @(negedge clk);
         in_valid = 1; in_last = ($urandom % 2) == 0;
         in_a = DW'($urandom); in_b = DW'($urandom);
      end
      @(negedge clk);
      in_valid = 0; in_last = 0;
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R1 valid in reset", longint'(res_valid), 0);
      check(res_sum == '0, "R1 sum in reset", longint'(res_sum), 0);
      rst_n = 1;
      repeat (4) @(negedge clk);
      check(res_valid == 1'b0, "R1 valid after reset", longint'(res_valid), 0);
      check(res_sum == '0, "R1 sum after reset", longint'(res_sum), 0);

      tag = "R1 first vector";  send_vec(8, 0, 0, 0);
      tag = "R2 random";
      for (int k = 0; k < 6; k++) send_vec(8 + 4 * k, 0, 0, 0);
      tag = "R3 gaps";
      for (int k = 0; k < 6; k++) send_vec(3 + 5 * k, 40, 0, 0);
      tag = "R4 lengths";
      for (int n = 1; n <= 11; n++) send_vec(n, 0, 0, 0);
      tag = "R4 max length extreme";  send_vec(ML, 0, 0, 1);
      tag = "R4 max length random";   send_vec(ML, 10, 0, 0);
      tag = "R6 ignored after last";
      for (int k = 0; k < 5; k++) send_vec(2 + k, 0, LAT, 0);

      tag = "R7 back to back";
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         in_valid = 1; in_last = ($urandom % 5) == 0;
         in_a = DW'($urandom); in_b = DW'($urandom);
      end
      @(negedge clk);
      in_valid = 1; in_last = 1;
      @(negedge clk);
      in_valid = 0; in_last = 0;
      wait_idle();
      repeat (4) @(negedge clk);
      summary();
   end
endmodule